// File: doc/BRIEF.md
# Pipelined Byte-Write Synchronous SRAM

This block is a single-port synchronous static memory for a burst-capable cache data path. An upstream burst sequencer supplies, each clock, a select flag and a word address. The memory registers the address, the write controls and the write data on the rising edge. It performs the array access in the following cycle and places read data in an output register, so a read presented at one edge shows its data after the next edge.

Each word is four lanes of nine bits. Three active-low controls decide which lanes a cycle writes: a global write, a write enable and one byte enable per lane. Any cycle that writes no lane is a read. An asynchronous output enable and a sleep input qualify a per-lane drive-enable vector, which stands in for tri-state pins. Sleep blocks all array activity and keeps the stored contents.

Top module: `pipe_sram_bw`

## Requirements
- R1: During and right after synchronous reset, `drive_o` is all zero and `rdata_o` is zero, and no access is pending.
- R2: A selected cycle with `gw_n_i` low writes all four lanes of the addressed word, whatever `we_n_i` and `be_n_i` hold.
- R3: A selected cycle with `gw_n_i` high and `we_n_i` low writes only those lanes i whose `be_n_i[i]` is low. Lane i is `wdata_i[9*i+8:9*i]`. The remaining lanes keep their old contents.
- R4: With `gw_n_i` high, `we_n_i` low and every `be_n_i` bit high, a selected cycle is a read.
- R5: With `gw_n_i` and `we_n_i` both high, a selected cycle is a read, and `be_n_i` is ignored.
- R6: A read sampled at edge N puts the addressed word on `rdata_o` after edge N+1. `drive_o` is all ones from then until edge N+2, provided `oe_n_i` is low and `sleep_i` is low.
- R7: `oe_n_i` acts without a clock: raising it clears `drive_o` at once, and lowering it restores the drive of a valid read at once.
- R8: In the output slot of a write cycle, `drive_o` is all zero, and `rdata_o` keeps its previous value.
- R9: A cycle with `sel_i` low starts no access, and its output slot (after the second edge) is undriven. A read sampled one edge earlier still delivers its data.
- R10: While `sleep_i` is high, `drive_o` is zero and commands are ignored. A write already registered is not performed, `rdata_o` holds, and array contents survive.
- R11: After `sleep_i` falls, the outputs stay undriven until a new read is commanded.
- R12: A read of an address written in the directly preceding cycle returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Access select from the burst sequencer |
| addr_i | input | ADDR_W | Word address |
| gw_n_i | input | 1 | Global write, active low |
| we_n_i | input | 1 | Lane-qualified write enable, active low |
| be_n_i | input | LANES | Per-lane byte enables, active low |
| wdata_i | input | LANES*LANE_W | Write data, lane i in bits 9i+8..9i |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request, active high |
| rdata_o | output | LANES*LANE_W | Registered read data |
| drive_o | output | LANES | Per-lane output drive enable |

## Verification
The hardest situation to reach is sleep arriving while an access is already in the input register. One example is a write sampled just before `sleep_i` rises, which must not reach the array. Another is a read that must not overwrite the held output. The stimulus sets these up with directed sequences: a read or write, then sleep raised on the next cycle with further write attempts to the same address, then a wake-up with no command. A later read of that address shows that nothing changed. Random traffic also pulses sleep at a low rate, mixed with deselects and output-enable toggles, against a bench memory model that follows the two-stage pipeline.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int unsigned LANES_DEF     = 4;
    localparam int unsigned LANE_BITS_DEF = 9;
    localparam int unsigned ADDR_BITS_DEF = 6;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

    // Kind of access a sampled command starts.
    function automatic cyc_e classify(input logic sel, input logic asleep, input logic any_lane);
        if (asleep || !sel) begin
            return CYC_IDLE;
        end
        return any_lane ? CYC_WRITE : CYC_READ;
    endfunction

endpackage

// File: rtl/psram_in_stage.sv
module psram_in_stage
    import psram_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_BITS_DEF,
    parameter int unsigned LANES  = LANES_DEF,
    parameter int unsigned LANE_W = LANE_BITS_DEF,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              gw_n_i,
    input  logic              we_n_i,
    input  logic [LANES-1:0]  be_n_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              sleep_i,
    output cyc_e              kind_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LANES-1:0]  lane_wr_o,
    output logic [DATA_W-1:0] wdata_o
);

    logic [LANES-1:0] lane_hit;
    cyc_e             kind_d;

    // Global write forces every lane; otherwise the write enable gates each byte enable.
    for (genvar g = 0; g < LANES; g++) begin : g_lane_dec
        assign lane_hit[g] = ~gw_n_i | (~we_n_i & ~be_n_i[g]);
    end

    assign kind_d = classify(sel_i, sleep_i, |lane_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_o    <= CYC_IDLE;
            lane_wr_o <= '0;
            addr_o    <= '0;
            wdata_o   <= '0;
        end else begin
            kind_o    <= kind_d;
            lane_wr_o <= (kind_d == CYC_WRITE) ? lane_hit : '0;
            if (kind_d != CYC_IDLE) begin
                addr_o  <= addr_i;
                wdata_o <= wdata_i;
            end
        end
    end

endmodule

// File: rtl/psram_array.sv
module psram_array #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned DEPTH  = 1 << ADDR_W,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic [LANES-1:0]  wr_lane_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    // One independent bank per lane so each lane has its own write strobe.
    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lane_i[g]) begin
                bank[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = bank[addr_i];
    end

endmodule

// File: rtl/psram_out_stage.sv
module psram_out_stage
    import psram_pkg::*;
#(
    parameter int unsigned LANES  = LANES_DEF,
    parameter int unsigned LANE_W = LANE_BITS_DEF,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  cyc_e              kind_i,
    input  logic [DATA_W-1:0] arr_data_i,
    input  logic              sleep_i,
    input  logic              oe_n_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              valid_o,
    output logic [LANES-1:0]  drive_o
);

    logic capture;

    assign capture = (kind_i == CYC_READ) && !sleep_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= capture;
            if (capture) begin
                rdata_o <= arr_data_i;
            end
        end
    end

    // Output enable and sleep act without a clock.
    assign drive_o = {LANES{valid_o & ~oe_n_i & ~sleep_i}};

endmodule

// File: rtl/pipe_sram_bw.sv
module pipe_sram_bw
    import psram_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_BITS_DEF,
    parameter int unsigned LANES  = LANES_DEF,
    parameter int unsigned LANE_W = LANE_BITS_DEF,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              gw_n_i,
    input  logic              we_n_i,
    input  logic [LANES-1:0]  be_n_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              oe_n_i,
    input  logic              sleep_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [LANES-1:0]  drive_o
);

    cyc_e              kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  lane_wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  arr_we;
    logic [DATA_W-1:0] arr_rdata;
    logic              out_valid;

    psram_in_stage #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) in_stage_i (
        .clk       (clk),
        .rst       (rst),
        .sel_i     (sel_i),
        .addr_i    (addr_i),
        .gw_n_i    (gw_n_i),
        .we_n_i    (we_n_i),
        .be_n_i    (be_n_i),
        .wdata_i   (wdata_i),
        .sleep_i   (sleep_i),
        .kind_o    (kind_q),
        .addr_o    (addr_q),
        .lane_wr_o (lane_wr_q),
        .wdata_o   (wdata_q)
    );

    // A registered write is dropped if sleep is high at its array edge.
    assign arr_we = (kind_q == CYC_WRITE && !sleep_i) ? lane_wr_q : '0;

    psram_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) array_i (
        .clk       (clk),
        .wr_lane_i (arr_we),
        .addr_i    (addr_q),
        .wdata_i   (wdata_q),
        .rdata_o   (arr_rdata)
    );

    psram_out_stage #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) out_stage_i (
        .clk        (clk),
        .rst        (rst),
        .kind_i     (kind_q),
        .arr_data_i (arr_rdata),
        .sleep_i    (sleep_i),
        .oe_n_i     (oe_n_i),
        .rdata_o    (rdata_o),
        .valid_o    (out_valid),
        .drive_o    (drive_o)
    );

endmodule

// File: rtl/psram_checker.sv
module psram_checker
    import psram_pkg::*;
#(
    parameter int unsigned LANES  = LANES_DEF,
    parameter int unsigned LANE_W = LANE_BITS_DEF,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_i,
    input logic              gw_n_i,
    input logic              we_n_i,
    input logic [LANES-1:0]  be_n_i,
    input logic              sleep_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic [LANES-1:0]  drive_o,
    input cyc_e              kind_q,
    input logic [LANES-1:0]  lane_wr_q,
    input logic              out_valid
);

    AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
        (sel_i && !sleep_i && !gw_n_i) |=> (lane_wr_q == '1)); // R2

    AST_BYTE_LANE_MASK: assert property (@(posedge clk) disable iff (rst)
        (sel_i && !sleep_i && gw_n_i && !we_n_i && !(&be_n_i)) |=> (lane_wr_q == ~$past(be_n_i))); // R3

    AST_NO_LANE_IS_READ: assert property (@(posedge clk) disable iff (rst)
        (sel_i && !sleep_i && gw_n_i && !we_n_i && (&be_n_i)) |=> (kind_q == CYC_READ)); // R4

    AST_PLAIN_READ: assert property (@(posedge clk) disable iff (rst)
        (sel_i && !sleep_i && gw_n_i && we_n_i) |=> (kind_q == CYC_READ && lane_wr_q == '0)); // R5

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (kind_q == CYC_READ && !sleep_i) |=> out_valid); // R6

    AST_WRITE_SLOT_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
        (kind_q == CYC_WRITE) |=> (drive_o == '0)); // R8

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!sel_i || sleep_i) |=> (kind_q == CYC_IDLE)); // R9

    AST_SLEEP_HOLDS_DATA: assert property (@(posedge clk) disable iff (rst)
        sleep_i |=> $stable(rdata_o)); // R10

endmodule

bind pipe_sram_bw psram_checker #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .sel_i     (sel_i),
    .gw_n_i    (gw_n_i),
    .we_n_i    (we_n_i),
    .be_n_i    (be_n_i),
    .sleep_i   (sleep_i),
    .rdata_o   (rdata_o),
    .drive_o   (drive_o),
    .kind_q    (kind_q),
    .lane_wr_q (lane_wr_q),
    .out_valid (out_valid)
);

// File: tb/pipe_sram_bw_tb_top.sv
module pipe_sram_bw_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int LN    = 4;
    localparam int LW    = 9;
    localparam int DW    = LN * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          gw_n = 1'b1;
    logic          we_n = 1'b1;
    logic [LN-1:0] be_n = '1;
    logic [DW-1:0] wdata = '0;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [DW-1:0] rdata;
    logic [LN-1:0] drive;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_sram_bw dut_i (
        .clk     (clk),
        .rst     (rst),
        .sel_i   (sel),
        .addr_i  (addr),
        .gw_n_i  (gw_n),
        .we_n_i  (we_n),
        .be_n_i  (be_n),
        .wdata_i (wdata),
        .oe_n_i  (oe_n),
        .sleep_i (sleep),
        .rdata_o (rdata),
        .drive_o (drive)
    );

    // Reference model: 0 idle, 1 read, 2 write
    logic [DW-1:0] ref_mem [DEPTH];
    int            m_kind  = 0;
    logic [AW-1:0] m_addr  = '0;
    logic [LN-1:0] m_mask  = '0;
    logic [DW-1:0] m_wd    = '0;
    logic          m_valid = 1'b0;
    logic [DW-1:0] m_out   = '0;
    int            n_checks = 0;
    int            n_fail   = 0;

    function automatic logic [LN-1:0] lanes_of(input logic gw, input logic we, input logic [LN-1:0] be);
        logic [LN-1:0] r;
        for (int i = 0; i < LN; i++) r[i] = !gw || (!we && !be[i]);
        return r;
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input logic [LN-1:0] mask);
        logic [DW-1:0] r;
        r = old;
        for (int i = 0; i < LN; i++) if (mask[i]) r[i*LW +: LW] = nw[i*LW +: LW];
        return r;
    endfunction

    task automatic check_vec(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        logic [LN-1:0] exp_drive;
        exp_drive = (m_valid && !oe_n && !sleep) ? '1 : '0;
        check_vec({tag, " drive"}, DW'(drive), DW'(exp_drive));
        check_vec({tag, " rdata"}, rdata, m_out);
    endtask

    task automatic model_edge();
        logic [LN-1:0] mk;
        if (rst) begin
            m_kind = 0; m_valid = 1'b0; m_out = '0; m_mask = '0;
        end else begin
            if (!sleep) begin
                if (m_kind == 2) ref_mem[m_addr] = merge(ref_mem[m_addr], m_wd, m_mask);
                if (m_kind == 1) m_out = ref_mem[m_addr];
            end
            m_valid = (m_kind == 1) && !sleep;
            mk = lanes_of(gw_n, we_n, be_n);
            if (sleep || !sel) m_kind = 0;
            else if (mk != '0) m_kind = 2;
            else m_kind = 1;
            m_mask = mk; m_addr = addr; m_wd = wdata;
        end
    endtask

    task automatic cyc(input string tag, input logic s, input logic [AW-1:0] a, input logic gw,
                       input logic we, input logic [LN-1:0] be, input logic [DW-1:0] wd,
                       input logic oe, input logic slp);
        @(negedge clk);
        compare(tag);
        sel = s; addr = a; gw_n = gw; we_n = we; be_n = be; wdata = wd; oe_n = oe; sleep = slp;
        @(posedge clk);
        #1;
        model_edge();
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, 1'b0, '0, 1'b1, 1'b1, '1, '0, 1'b0, 1'b0);
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a);
        cyc(tag, 1'b1, a, 1'b1, 1'b1, '1, '0, 1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [DW-1:0] keep3;
        void'($urandom(32'h00c0ffee));
        repeat (3) @(posedge clk);
        #1;
        model_edge();
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state on the outputs
        check_vec("R1 drive after reset", DW'(drive), '0);
        check_vec("R1 rdata after reset", rdata, '0);
        idle("R1", 2);

        // Fill every word with a global write (R2)
        for (int a = 0; a < DEPTH; a++)
            cyc("R2", 1'b1, AW'(a), 1'b0, 1'b1, '1, DW'(a) * 36'h0_2468_ACE1 + 36'h5, 1'b0, 1'b0);
        idle("R2", 2);
        // R2: global write overrides we_n high and all byte enables high
        cyc("R2", 1'b1, 6'd5, 1'b0, 1'b1, 4'hF, 36'hA_BCDE_F012, 1'b0, 1'b0);
        rd("R2", 6'd5);
        idle("R2", 2);
        // R3: only lanes 0 and 2 (be_n = 1010) written
        cyc("R3", 1'b1, 6'd9, 1'b1, 1'b0, 4'b1010, 36'hF_FFFF_FFFF, 1'b0, 1'b0);
        rd("R3", 6'd9);
        idle("R3", 2);
        check_vec("R3 lane merge", rdata, merge(DW'(9) * 36'h0_2468_ACE1 + 36'h5, 36'hF_FFFF_FFFF, 4'b0101));
        // R4: we_n low but no byte enable -> read, memory unchanged
        cyc("R4", 1'b1, 6'd9, 1'b1, 1'b0, 4'hF, 36'h0_0000_0000, 1'b0, 1'b0);
        idle("R4", 2);
        // R5: both write controls high -> read despite byte enables low
        cyc("R5", 1'b1, 6'd11, 1'b1, 1'b1, 4'h0, 36'h1_1111_1111, 1'b0, 1'b0);
        idle("R5", 2);
        rd("R5", 6'd11);
        idle("R5", 2);
        // R12: write then immediate read of the same word
        cyc("R12", 1'b1, 6'd12, 1'b0, 1'b1, '1, 36'h7_7654_3210, 1'b0, 1'b0);
        rd("R12", 6'd12);
        idle("R12", 2);
        // R6 / R9: read followed by deselect still delivers, then releases
        rd("R6", 6'd3);
        idle("R9", 3);
        // R8: read then write: write slot undriven
        rd("R8", 6'd4);
        cyc("R8", 1'b1, 6'd20, 1'b1, 1'b0, 4'b1100, 36'h3_3333_3333, 1'b0, 1'b0);
        idle("R8", 3);
        // R7: asynchronous output enable
        rd("R7", 6'd7);
        idle("R7", 1);
        check_vec("R7 drive with oe low", DW'(drive), DW'({LN{1'b1}}));
        oe_n = 1'b1;
        #1;
        check_vec("R7 drive after oe rise", DW'(drive), '0);
        oe_n = 1'b0;
        #1;
        check_vec("R7 drive after oe fall", DW'(drive), DW'({LN{1'b1}}));
        idle("R7", 2);
        // R10: write pending when sleep rises, further writes during sleep
        keep3 = ref_mem[3];
        rd("R10", 6'd8);
        cyc("R10", 1'b1, 6'd3, 1'b0, 1'b0, 4'h0, 36'h0_0000_0001, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++)
            cyc("R10", 1'b1, 6'd3, 1'b0, 1'b0, 4'h0, 36'h9_9999_9999, 1'b0, 1'b1);
        // R11: wake with no command
        idle("R11", 3);
        check_vec("R11 drive idle after wake", DW'(drive), '0);
        rd("R10", 6'd3);
        idle("R10", 2);
        check_vec("R10 contents kept through sleep", rdata, keep3);

        // Random mix checked against the model (R6 pipeline)
        for (int n = 0; n < 3000; n++) begin
            logic s, gw, we, oe, slp;
            logic [LN-1:0] be;
            s   = ($urandom % 8) != 0;
            gw  = ($urandom % 6) != 0;
            we  = ($urandom % 2) != 0;
            be  = LN'($urandom);
            oe  = ($urandom % 8) == 0;
            slp = ($urandom % 32) == 0;
            cyc("R6", s, AW'($urandom), gw, we, be, {4'($urandom), 32'($urandom)}, oe, slp);
        end
        idle("R6", 3);
        summary();
    end

endmodule